// File: doc/BRIEF.md
# Timed Instruction Pulse Sequencer

This block is a small microprogrammed controller that drives a bank of digital output lines. It steps through a program memory of instruction words. Each word carries an output pattern, an opcode, an argument and a length. The pattern stays on the outputs for exactly the number of clocks the instruction asks for, with one-clock resolution. When that time runs out, the opcode picks the next address. Plain steps, jumps, counted loops, subroutine calls and returns, stretched delays, trigger waits and halts are all handled in hardware. Loops and calls each have their own eight-entry stack.

A host fills the program memory through a write port that takes the four instruction fields on separate buses. The host then launches execution with a start pulse, or with a rising edge on the hardware trigger line while the block is idle. A stop input halts execution at once. A hardware reset input returns the block to its power-up state. Four status lines and an error flag report what the controller is doing. Every halt sets the outputs to zero and the program counter to 0, so every run begins at address 0.

Top module: `pulse_seq`

## Requirements
- R1: After `rst_n` is released, and one clock after `hw_rst` is sampled high, `pulse_out` is 0, only `st_reset` is high among the status lines, and `err` is 0.
- R2: While idle, a high `start` or a rising edge of `hw_trig` sampled at a clock edge loads address 0. On that same edge, `pulse_out` shows the pattern stored at address 0.
- R3: An instruction holds its pattern for exactly max(length, m) clocks. m is 5 for loop start (opcode 2), loop end (3) and branch (6), and 6 for every other opcode. The pattern does not change at any other time while running.
- R4: Continue (opcode 0) and every unassigned opcode (9 to 15) move to the next address. Branch (opcode 6) moves to the address in the low bits of the argument.
- R5: Loop start (opcode 2) with argument N pushes a loop frame and moves on. The instructions after it, up to and including the matching loop end (opcode 3), then run N times in total. An argument of 0 is treated as 1.
- R6: Call (opcode 4) pushes the address after itself and jumps to its argument. Return (opcode 5) pops that address and resumes there. Calls can be nested 8 deep.
- R7: Long delay (opcode 7) holds its pattern for max(length, 6) times max(argument, 1) clocks, then moves to the next address.
- R8: Wait (opcode 8) shows its pattern and raises `st_waiting` until a rising edge of `hw_trig` is sampled. The next instruction's pattern appears exactly 8 clock edges after that sampling edge.
- R9: Stop (opcode 1) holds its pattern for its length. The block then halts with `pulse_out` at 0 and `st_stopped` high.
- R10: A high `stop` input while running halts the block on that edge: `pulse_out` goes to 0 and `st_stopped` goes high. The next start begins again at address 0.
- R11: A call or loop start made when its stack already holds 8 entries, and a return or loop end made when its stack is empty, halt the block and set `err`. `err` stays high until the next start or hardware reset.
- R12: Exactly one of `st_stopped`, `st_reset` and `st_running` is high at any time. `st_waiting` is high only while `st_running` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Program memory write strobe |
| wr_addr | input | ADDR_W | Address to write |
| wr_pat | input | OUT_W | Output pattern field of the word |
| wr_op | input | 4 | Opcode field of the word |
| wr_arg | input | 20 | Argument field (target, loop count, repeat count) |
| wr_len | input | 32 | Length field in clocks |
| start | input | 1 | Begin execution at address 0 when idle |
| stop | input | 1 | Halt execution immediately |
| hw_trig | input | 1 | Trigger: its rising edge starts an idle block or releases a wait |
| hw_rst | input | 1 | Synchronous return to the power-up state |
| pulse_out | output | OUT_W | Registered output pattern |
| st_stopped | output | 1 | Idle after a program has run |
| st_reset | output | 1 | Idle since reset, never started |
| st_running | output | 1 | Executing, including waits |
| st_waiting | output | 1 | Paused on a wait instruction |
| err | output | 1 | Stack overflow or underflow caused the last halt |

## Verification
The assertions assume that the host does not rewrite the instruction being fetched on the same edge it is loaded. They also assume that `stop`, `start` and `hw_trig` are clean, synchronous levels. The duration check assumes every length the host writes is below 16 or above the opcode's minimum, which any correct encoding satisfies because lengths below the minimum are raised to it. The bench writes the program only while the block is idle, and it drives every control on the falling edge. Each scenario halts the block before the next program is loaded.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int OP_W  = 4;
  localparam int ARG_W = 20;
  localparam int LEN_W = 32;

  localparam logic [OP_W-1:0] OP_CONT = 4'd0;
  localparam logic [OP_W-1:0] OP_STOP = 4'd1;
  localparam logic [OP_W-1:0] OP_LOOP = 4'd2;
  localparam logic [OP_W-1:0] OP_ENDL = 4'd3;
  localparam logic [OP_W-1:0] OP_CALL = 4'd4;
  localparam logic [OP_W-1:0] OP_RET  = 4'd5;
  localparam logic [OP_W-1:0] OP_BRA  = 4'd6;
  localparam logic [OP_W-1:0] OP_LDLY = 4'd7;
  localparam logic [OP_W-1:0] OP_WAIT = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_LAT} seq_state_e;

  // shortest legal duration of an opcode
  function automatic logic [LEN_W-1:0] min_len(input logic [OP_W-1:0] op);
    if (op == OP_LOOP || op == OP_ENDL || op == OP_BRA) return LEN_W'(5);
    return LEN_W'(6);
  endfunction

  // duration actually used for one pass of an instruction
  function automatic logic [LEN_W-1:0] eff_len(input logic [OP_W-1:0] op,
                                               input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] lo;
    lo = min_len(op);
    return (len < lo) ? lo : len;
  endfunction

  // extra passes after the first one (a count of 0 behaves as 1)
  function automatic logic [ARG_W-1:0] extra_passes(input logic [ARG_W-1:0] n);
    return (n == '0) ? '0 : n - ARG_W'(1);
  endfunction

endpackage

// File: rtl/pseq_mem.sv
module pseq_mem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 77
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_word;
  end

  // asynchronous read: the next word is ready in the cycle it is chosen
  assign rd_word = store[rd_addr];
endmodule

// File: rtl/pseq_stack.sv
module pseq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic [W-1:0]  frames [DEPTH];
  logic [PW-1:0] ptr;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] new_idx;

  assign top_idx = IW'(ptr - PW'(1));
  assign new_idx = IW'(ptr);
  assign full    = (ptr == PW'(DEPTH));
  assign empty   = (ptr == '0);
  assign top     = frames[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr <= '0;
    else if (clr)             ptr <= '0;
    else if (push && !full)   ptr <= ptr + PW'(1);
    else if (pop && !empty)   ptr <= ptr - PW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_frame
    always_ff @(posedge clk) begin
      if (!clr && push && !full && new_idx == IW'(g))        frames[g] <= din;
      else if (!clr && upd && !empty && top_idx == IW'(g))   frames[g] <= din;
    end
  end
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int LEN_W = 32,
  parameter int REP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic [REP_W-1:0] reps,
  input  logic             run,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic [REP_W-1:0] rep;

  assign done = (cnt == '0) && (rep == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rep <= '0; len_q <= '0;
    end else if (clr) begin
      cnt <= '0; rep <= '0;
    end else if (load) begin
      cnt   <= len - LEN_W'(1);
      len_q <= len;
      rep   <= reps;
    end else if (run && !done) begin
      if (cnt != '0) cnt <= cnt - LEN_W'(1);
      else begin
        rep <= rep - REP_W'(1);
        cnt <= len_q - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
  import pseq_pkg::*;
#(
  parameter int OUT_W    = 21,
  parameter int ADDR_W   = 8,
  parameter int STK_D    = 8,
  parameter int WAIT_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OUT_W-1:0]  wr_pat,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [ARG_W-1:0]  wr_arg,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              start,
  input  logic              stop,
  input  logic              hw_trig,
  input  logic              hw_rst,
  output logic [OUT_W-1:0]  pulse_out,
  output logic              st_stopped,
  output logic              st_reset,
  output logic              st_running,
  output logic              st_waiting,
  output logic              err
);
  localparam int WORD_W = OUT_W + OP_W + ARG_W + LEN_W;
  localparam int LFR_W  = ADDR_W + ARG_W;
  localparam int LAT_W  = $clog2(WAIT_LAT + 1);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc, pc_inc, ld_addr;
  logic [OP_W-1:0]   op_q;
  logic [ARG_W-1:0]  arg_q;
  logic [LAT_W-1:0]  lat_cnt;
  logic              trig_q, fresh_q, err_q;
  logic [OUT_W-1:0]  out_q;

  logic [WORD_W-1:0] rd_word;
  logic [OUT_W-1:0]  rd_pat;
  logic [OP_W-1:0]   rd_op;
  logic [ARG_W-1:0]  rd_arg;
  logic [LEN_W-1:0]  rd_len;

  // named internal events, also observed by the checker
  logic trig_rise, go_now, ld_now, halt_now, fault, ctl_kill, end_now, lat_done;

  logic              c_push, c_pop, c_full, c_empty;
  logic [ADDR_W-1:0] c_top;
  logic              l_push, l_pop, l_upd, l_full, l_empty;
  logic [LFR_W-1:0]  l_top, l_din;
  logic              tmr_done;

  assign rd_pat = rd_word[WORD_W-1 -: OUT_W];
  assign rd_op  = rd_word[ARG_W+LEN_W +: OP_W];
  assign rd_arg = rd_word[LEN_W +: ARG_W];
  assign rd_len = rd_word[LEN_W-1:0];

  assign pc_inc    = pc + ADDR_W'(1);
  assign trig_rise = hw_trig & ~trig_q;
  assign ctl_kill  = hw_rst | (stop & (state != S_IDLE));
  assign go_now    = (state == S_IDLE) && (start || trig_rise) && !hw_rst;
  assign end_now   = (state == S_RUN) && tmr_done;
  assign lat_done  = (state == S_LAT) && (lat_cnt == '0);

  pseq_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_word({wr_pat, wr_op, wr_arg, wr_len}),
    .rd_addr(ld_addr), .rd_word(rd_word)
  );

  pseq_stack #(.DEPTH(STK_D), .W(ADDR_W)) u_call_stk (
    .clk(clk), .rst_n(rst_n), .clr(ctl_kill | go_now),
    .push(c_push), .pop(c_pop), .upd(1'b0), .din(pc_inc),
    .top(c_top), .full(c_full), .empty(c_empty)
  );

  pseq_stack #(.DEPTH(STK_D), .W(LFR_W)) u_loop_stk (
    .clk(clk), .rst_n(rst_n), .clr(ctl_kill | go_now),
    .push(l_push), .pop(l_pop), .upd(l_upd), .din(l_din),
    .top(l_top), .full(l_full), .empty(l_empty)
  );

  pseq_timer #(.LEN_W(LEN_W), .REP_W(ARG_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ctl_kill), .load(ld_now),
    .len(eff_len(rd_op, rd_len)),
    .reps((rd_op == OP_LDLY) ? extra_passes(rd_arg) : '0),
    .run(state == S_RUN), .done(tmr_done)
  );

  // next-address decision, taken when an instruction's time runs out
  always_comb begin
    ld_now = 1'b0; halt_now = 1'b0; fault = 1'b0;
    ld_addr = pc_inc;
    c_push = 1'b0; c_pop = 1'b0;
    l_push = 1'b0; l_pop = 1'b0; l_upd = 1'b0;
    l_din  = {pc_inc, extra_passes(arg_q)};
    if (go_now) begin
      ld_now = 1'b1; ld_addr = '0;
    end else if (lat_done) begin
      ld_now = 1'b1;
    end else if (end_now) begin
      ld_now = 1'b1;
      case (op_q)
        OP_STOP: begin ld_now = 1'b0; halt_now = 1'b1; end
        OP_LOOP: if (l_full) fault = 1'b1; else l_push = 1'b1;
        OP_ENDL: begin
          if (l_empty) fault = 1'b1;
          else if (l_top[ARG_W-1:0] != '0) begin
            l_upd   = 1'b1;
            l_din   = {l_top[LFR_W-1 -: ADDR_W], l_top[ARG_W-1:0] - ARG_W'(1)};
            ld_addr = l_top[LFR_W-1 -: ADDR_W];
          end else l_pop = 1'b1;
        end
        OP_CALL: begin
          if (c_full) fault = 1'b1;
          else begin c_push = 1'b1; ld_addr = arg_q[ADDR_W-1:0]; end
        end
        OP_RET: begin
          if (c_empty) fault = 1'b1;
          else begin c_pop = 1'b1; ld_addr = c_top; end
        end
        OP_BRA: ld_addr = arg_q[ADDR_W-1:0];
        default: ;
      endcase
      if (fault) begin ld_now = 1'b0; halt_now = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pc <= '0; out_q <= '0; op_q <= OP_CONT; arg_q <= '0;
      lat_cnt <= '0; trig_q <= 1'b0; fresh_q <= 1'b1; err_q <= 1'b0;
    end else begin
      trig_q <= hw_trig;
      if (hw_rst) begin
        state <= S_IDLE; pc <= '0; out_q <= '0; fresh_q <= 1'b1; err_q <= 1'b0;
      end else if (ctl_kill || halt_now) begin
        state <= S_IDLE; pc <= '0; out_q <= '0;
        if (halt_now && !ctl_kill) err_q <= fault;
      end else if (ld_now) begin
        state <= (rd_op == OP_WAIT) ? S_WAIT : S_RUN;
        pc    <= ld_addr;
        out_q <= rd_pat;
        op_q  <= rd_op;
        arg_q <= rd_arg;
        if (go_now) begin fresh_q <= 1'b0; err_q <= 1'b0; end
      end else if (state == S_WAIT && trig_rise) begin
        state   <= S_LAT;
        lat_cnt <= LAT_W'(WAIT_LAT - 1);
      end else if (state == S_LAT) begin
        lat_cnt <= lat_cnt - LAT_W'(1);
      end
    end
  end

  assign pulse_out  = out_q;
  assign st_running = (state != S_IDLE);
  assign st_waiting = (state == S_WAIT);
  assign st_reset   = (state == S_IDLE) && fresh_q;
  assign st_stopped = (state == S_IDLE) && !fresh_q;
  assign err        = err_q;
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
  parameter int OUT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             hw_rst,
  input logic [OUT_W-1:0] pulse_out,
  input logic             st_stopped,
  input logic             st_reset,
  input logic             st_running,
  input logic             st_waiting,
  input logic             err,
  input logic             ld_now,
  input logic             halt_now,
  input logic             trig_rise
);
  // cycles since the last instruction load, saturating
  logic [3:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_q <= '0;
    else if (ld_now)        since_q <= '0;
    else if (since_q != 4'hF) since_q <= since_q + 4'd1;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !st_running |-> pulse_out == '0);                                   // R9
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_stopped, st_reset, st_running}) && (!st_waiting || st_running)); // R12
  AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_running && !ld_now && !halt_now && !stop && !hw_rst) |=> $stable(pulse_out)); // R3
  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_now && st_running) |-> since_q >= 4'd4);                        // R3
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (st_stopped && pulse_out == '0));                    // R11
  AST_HWRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (st_reset && !err && pulse_out == '0));                  // R1
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_waiting && !trig_rise && !stop && !hw_rst) |=> st_waiting);     // R8
endmodule

bind pulse_seq pulse_seq_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .hw_rst(hw_rst),
  .pulse_out(pulse_out), .st_stopped(st_stopped), .st_reset(st_reset),
  .st_running(st_running), .st_waiting(st_waiting), .err(err),
  .ld_now(ld_now), .halt_now(halt_now), .trig_rise(trig_rise)
);

// File: tb/pulse_seq_bench.sv
module pulse_seq_bench;
  localparam int OUT_W = 21;
  localparam int ADDR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [OUT_W-1:0] wr_pat = '0;
  logic [3:0] wr_op = '0;
  logic [19:0] wr_arg = '0;
  logic [31:0] wr_len = '0;
  logic start = 1'b0, stop = 1'b0, hw_trig = 1'b0, hw_rst = 1'b0;
  logic [OUT_W-1:0] pulse_out;
  logic st_stopped, st_reset, st_running, st_waiting, err;

  int total = 0, bad = 0;
  logic [OUT_W-1:0] cap [0:159];
  logic [OUT_W-1:0] exp_v [0:159];
  int exp_n = 0;

  always #5 clk = ~clk;

  pulse_seq #(.OUT_W(OUT_W), .ADDR_W(ADDR_W)) u_pulse_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_pat(wr_pat), .wr_op(wr_op), .wr_arg(wr_arg), .wr_len(wr_len),
    .start(start), .stop(stop), .hw_trig(hw_trig), .hw_rst(hw_rst),
    .pulse_out(pulse_out), .st_stopped(st_stopped), .st_reset(st_reset),
    .st_running(st_running), .st_waiting(st_waiting), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic put(input int a, input logic [OUT_W-1:0] p, input logic [3:0] op,
                     input logic [19:0] arg, input logic [31:0] len);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_pat = p; wr_op = op; wr_arg = arg; wr_len = len;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic exp_clear();
    exp_n = 0;
    for (int i = 0; i < 160; i++) exp_v[i] = '0;
  endtask

  task automatic seg(input logic [OUT_W-1:0] p, input int len);
    for (int i = 0; i < len; i++) begin exp_v[exp_n] = p; exp_n++; end
  endtask

  // pulse start (or trigger) for one cycle; cap[i] = output after launch edge + i
  task automatic launch_capture(input int n, input bit by_trig);
    @(negedge clk);
    if (by_trig) hw_trig = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cap[0] = pulse_out;
    for (int i = 1; i < n; i++) begin @(negedge clk); cap[i] = pulse_out; end
    hw_trig = 1'b0;
  endtask

  task automatic check_trace(input int n, input string req);
    int first = -1;
    for (int i = 0; i < n; i++) if (first < 0 && cap[i] !== exp_v[i]) first = i;
    if (first < 0) check(1'b1, req, "trace", 0, 0);
    else check(1'b0, req, $sformatf("trace cycle %0d", first), longint'(cap[first]), longint'(exp_v[first]));
  endtask

  task automatic t_reset();
    check(pulse_out == '0, "R1", "out after reset", longint'(pulse_out), 0);
    check(st_reset && !st_stopped && !st_running && !st_waiting && !err, "R1", "status after reset",
          longint'({st_reset, st_stopped, st_running, st_waiting, err}), 5'b10000);
  endtask

  // R2 R4: pattern masking, continue, branch back to 0
  task automatic t_branch();
    put(0, 21'h1FFFFF, 4'd0, 20'd0, 32'd7);
    put(1, 21'h000002, 4'd6, 20'd0, 32'd5);
    exp_clear(); seg(21'h1FFFFF, 7); seg(21'h2, 5); seg(21'h1FFFFF, 7); seg(21'h2, 5);
    launch_capture(24, 1'b0);
    check_trace(24, "R4");
    check(st_running, "R2", "running after start", longint'(st_running), 1);
    halt();
  endtask

  // R3 R4: minimum lengths, unassigned opcode, branch forward, R9 stop
  task automatic t_minlen();
    put(0, 21'h10, 4'd12, 20'd0, 32'd2);
    put(1, 21'h20, 4'd6, 20'd3, 32'd0);
    put(2, 21'h40, 4'd0, 20'd0, 32'd6);
    put(3, 21'h80, 4'd1, 20'd0, 32'd1);
    exp_clear(); seg(21'h10, 6); seg(21'h20, 5); seg(21'h80, 6);
    launch_capture(22, 1'b0);
    check_trace(22, "R3");
    check(st_stopped && !st_running, "R9", "stopped after stop op",
          longint'({st_stopped, st_running}), 2'b10);
  endtask

  // R5: loop of 3 passes
  task automatic t_loop();
    put(0, 21'h1, 4'd2, 20'd3, 32'd5);
    put(1, 21'h2, 4'd0, 20'd0, 32'd6);
    put(2, 21'h3, 4'd3, 20'd0, 32'd5);
    put(3, 21'h4, 4'd1, 20'd0, 32'd6);
    exp_clear(); seg(21'h1, 5);
    for (int k = 0; k < 3; k++) begin seg(21'h2, 6); seg(21'h3, 5); end
    seg(21'h4, 6);
    launch_capture(48, 1'b0);
    check_trace(48, "R5");
  endtask

  // R6: call and return
  task automatic t_call();
    put(0, 21'hA, 4'd4, 20'd3, 32'd6);
    put(1, 21'hB, 4'd0, 20'd0, 32'd6);
    put(2, 21'hC, 4'd1, 20'd0, 32'd6);
    put(3, 21'hD, 4'd0, 20'd0, 32'd6);
    put(4, 21'hE, 4'd5, 20'd0, 32'd6);
    exp_clear(); seg(21'hA, 6); seg(21'hD, 6); seg(21'hE, 6); seg(21'hB, 6); seg(21'hC, 6);
    launch_capture(34, 1'b0);
    check_trace(34, "R6");
  endtask

  // R7: long delay, 3 passes of 6
  task automatic t_ldly();
    put(0, 21'h15, 4'd7, 20'd3, 32'd6);
    put(1, 21'h16, 4'd1, 20'd0, 32'd6);
    exp_clear(); seg(21'h15, 18); seg(21'h16, 6);
    launch_capture(28, 1'b0);
    check_trace(28, "R7");
  endtask

  // R8: wait for trigger, 8-edge release latency
  task automatic t_wait();
    put(0, 21'h55, 4'd8, 20'd0, 32'd6);
    put(1, 21'hAA, 4'd1, 20'd0, 32'd6);
    exp_clear(); seg(21'h55, 12);
    launch_capture(12, 1'b0);
    check_trace(12, "R8");
    check(st_waiting && st_running, "R8", "waiting status", longint'(st_waiting), 1);
    @(negedge clk); hw_trig = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(pulse_out == 21'h55, "R8", $sformatf("held %0d", i), longint'(pulse_out), 21'h55);
    end
    @(negedge clk);
    check(pulse_out == 21'hAA, "R8", "released pattern", longint'(pulse_out), 21'hAA);
    hw_trig = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // R2: rising trigger starts an idle block at address 0
  task automatic t_trig_start();
    put(0, 21'h3, 4'd0, 20'd0, 32'd6);
    put(1, 21'h4, 4'd1, 20'd0, 32'd6);
    exp_clear(); seg(21'h3, 6); seg(21'h4, 6);
    launch_capture(14, 1'b1);
    check_trace(14, "R2");
  endtask

  // R10: stop input, then restart from 0
  task automatic t_stop_in();
    put(0, 21'h11, 4'd0, 20'd0, 32'd6);
    put(1, 21'h22, 4'd6, 20'd0, 32'd5);
    launch_capture(8, 1'b0);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(pulse_out == '0 && st_stopped, "R10", "halt on stop",
          longint'({st_stopped, pulse_out}), longint'({1'b1, 21'h0}));
    exp_clear(); seg(21'h11, 6); seg(21'h22, 5);
    launch_capture(11, 1'b0);
    check_trace(11, "R10");
    halt();
  endtask

  // R1: hardware reset mid-run
  task automatic t_hwrst();
    launch_capture(4, 1'b0);
    @(negedge clk); hw_rst = 1'b1;
    @(negedge clk); hw_rst = 1'b0;
    check(pulse_out == '0 && st_reset && !st_running, "R1", "after hw reset",
          longint'({st_reset, st_running, pulse_out}), longint'({2'b10, 21'h0}));
  endtask

  // R11: stack overflow and underflow
  task automatic t_errors();
    put(0, 21'h7, 4'd4, 20'd0, 32'd6);
    launch_capture(60, 1'b0);
    check(cap[53] == 21'h7 && cap[54] == '0, "R11", "call overflow halt edge",
          longint'(cap[54]), 0);
    check(err && st_stopped, "R11", "err after call overflow", longint'(err), 1);
    put(0, 21'h9, 4'd5, 20'd0, 32'd6);
    launch_capture(10, 1'b0);
    check(cap[0] == 21'h9 && cap[6] == '0 && err, "R11", "return underflow",
          longint'({err, cap[6]}), longint'({1'b1, 21'h0}));
    put(0, 21'h1, 4'd2, 20'd2, 32'd5);
    put(1, 21'h2, 4'd6, 20'd0, 32'd5);
    launch_capture(2, 1'b0);
    check(!err, "R11", "err cleared by start", longint'(err), 0);
    repeat (90) @(negedge clk);
    check(err && st_stopped && pulse_out == '0, "R11", "loop overflow",
          longint'(err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_branch();
    t_minlen();
    t_loop();
    t_call();
    t_ldly();
    t_wait();
    t_trig_start();
    t_stop_in();
    t_hwrst();
    t_errors();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule